// File: doc/BRIEF.md
# Command-Gated Three-Light Sequencer

This block is a small Moore state machine that lights exactly one of three lamps (green, yellow, red) at a time. While its command input is high, it moves one step per clock: green, then yellow, then red, then green again. Once a cycle has started, it always runs on to red. The command is looked at only while red is lit. If the command is low at that point, the machine stays on red until the command returns.

The state sits in two flip-flops with a fixed code: 00 is red, 01 is green and 10 is yellow. The fourth code, 11, shows yellow and goes back to red on the next edge without help. A preset input forces that code so a testbench can check the recovery path. A build option removes the preset. A synchronous reset parks the machine on red.

Top module: `lamp_sequencer`

## Requirements
- R1: In every cycle after reset, exactly one of `lamp_red_o`, `lamp_yel_o` and `lamp_grn_o` is high.
- R2: With `rst` high at a rising edge, red is lit after that edge, whatever `preset_i` and `cmd_i` are.
- R3: From red (code 00), with `cmd_i` = 1 and no preset, the next edge lights green (code 01).
- R4: From red, with `cmd_i` = 0 and no preset, red stays lit at every edge until `cmd_i` is 1.
- R5: From green, with no preset, the next edge lights yellow (code 10) whether `cmd_i` is 0 or 1.
- R6: From yellow, with no preset, the next edge lights red whether `cmd_i` is 0 or 1.
- R7: With `PRESET_EN` = 1 and `preset_i` high at an edge (without reset), the state becomes code 11 and yellow is lit after that edge, overriding the normal step.
- R8: From code 11, with no preset, the next edge lights red whatever `cmd_i` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to red |
| cmd_i | input | 1 | Run command, synchronous to clk, sampled only while red is lit |
| preset_i | input | 1 | Test preset that forces state code 11 |
| lamp_red_o | output | 1 | Red lamp |
| lamp_yel_o | output | 1 | Yellow lamp |
| lamp_grn_o | output | 1 | Green lamp |

## Verification
The bench builds the block with `PRESET_EN` = 1. This makes the unused code 11 reachable, so the path back to red from that code can be exercised directly. It also lets the bench check the priority of reset over preset, and of preset over a step that is already in progress. A table of vectors covers several things: dropping the command part way through a cycle, parking on red, and several preset entries. A random phase then compares the lamps with a reference model while both command and preset change freely.

// File: rtl/lamp_seq_pkg.sv
package lamp_seq_pkg;
   localparam int STATE_W = 2;
   typedef logic [STATE_W-1:0] lamp_code_t;
   // fixed codes; bit 1 alone decodes yellow, all-zero decodes red
   localparam lamp_code_t CODE_RED = 2'b00;
   localparam lamp_code_t CODE_GRN = 2'b01;
   localparam lamp_code_t CODE_YEL = 2'b10;
   localparam lamp_code_t CODE_TRAP = 2'b11;
   typedef struct packed {
      logic red;
      logic yel;
      logic grn;
   } lamp_set_t;
endpackage

// File: rtl/lamp_step_logic.sv
module lamp_step_logic
   import lamp_seq_pkg::*;
(
   input  lamp_code_t cur_i,
   input  logic       cmd_i,
   output lamp_code_t nxt_o
);
   // low bit only set when leaving red under command
   always_comb begin
      nxt_o[0] = cmd_i & ~cur_i[1] & ~cur_i[0];
      nxt_o[1] = ~cur_i[1] & cur_i[0];
   end
endmodule

// File: rtl/lamp_state_reg.sv
module lamp_state_reg
   import lamp_seq_pkg::*;
#(
   parameter bit PRESET_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       preset_i,
   input  lamp_code_t nxt_i,
   output lamp_code_t cur_o
);
   generate
      if (PRESET_EN) begin : g_preset
         always_ff @(posedge clk) begin
            if (rst)           cur_o <= CODE_RED;
            else if (preset_i) cur_o <= CODE_TRAP;
            else               cur_o <= nxt_i;
         end
      end else begin : g_plain
         logic unused_preset;
         assign unused_preset = preset_i;
         always_ff @(posedge clk) begin
            if (rst) cur_o <= CODE_RED;
            else     cur_o <= nxt_i;
         end
      end
   endgenerate
endmodule

// File: rtl/lamp_decode.sv
module lamp_decode
   import lamp_seq_pkg::*;
(
   input  lamp_code_t cur_i,
   output lamp_set_t  lamps_o
);
   always_comb begin
      lamps_o.red = ~(cur_i[1] | cur_i[0]);
      lamps_o.yel = cur_i[1];
      lamps_o.grn = ~(lamps_o.red | lamps_o.yel);
   end
endmodule

// File: rtl/lamp_sequencer.sv
module lamp_sequencer
   import lamp_seq_pkg::*;
#(
   parameter bit PRESET_EN = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic cmd_i,
   input  logic preset_i,
   output logic lamp_red_o,
   output logic lamp_yel_o,
   output logic lamp_grn_o
);
   generate
      if (STATE_W != 2) begin : g_bad_width
         $error("lamp_sequencer: state width must be 2");
      end
   endgenerate

   lamp_code_t cur_code;
   lamp_code_t nxt_code;
   lamp_set_t  lamps;

   lamp_step_logic i_step (
      .cur_i (cur_code),
      .cmd_i (cmd_i),
      .nxt_o (nxt_code)
   );

   lamp_state_reg #(.PRESET_EN(PRESET_EN)) i_reg (
      .clk      (clk),
      .rst      (rst),
      .preset_i (preset_i),
      .nxt_i    (nxt_code),
      .cur_o    (cur_code)
   );

   lamp_decode i_dec (
      .cur_i   (cur_code),
      .lamps_o (lamps)
   );

   assign lamp_red_o = lamps.red;
   assign lamp_yel_o = lamps.yel;
   assign lamp_grn_o = lamps.grn;
endmodule

// File: rtl/lamp_sequencer_chk.sv
module lamp_sequencer_chk #(
   parameter bit PRESET_EN = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic cmd_i,
   input logic preset_i,
   input logic lamp_red_o,
   input logic lamp_yel_o,
   input logic lamp_grn_o
);
   logic pre_act;
   assign pre_act = PRESET_EN & preset_i;

   // R1
   one_lamp_chk: assert property (@(posedge clk) disable iff (rst)
      $countones({lamp_red_o, lamp_yel_o, lamp_grn_o}) == 1);

   // R2
   reset_red_chk: assert property (@(posedge clk)
      rst |=> lamp_red_o);

   // R3
   red_go_chk: assert property (@(posedge clk) disable iff (rst)
      (lamp_red_o && cmd_i && !pre_act) |=> lamp_grn_o);

   // R4
   red_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (lamp_red_o && !cmd_i && !pre_act) |=> lamp_red_o);

   // R5
   grn_step_chk: assert property (@(posedge clk) disable iff (rst)
      (lamp_grn_o && !pre_act) |=> lamp_yel_o);

   // R6 R8 (codes 10 and 11 both show yellow)
   yel_step_chk: assert property (@(posedge clk) disable iff (rst)
      (lamp_yel_o && !pre_act) |=> lamp_red_o);

   // R7
   preset_force_chk: assert property (@(posedge clk) disable iff (rst)
      pre_act |=> lamp_yel_o);
endmodule

bind lamp_sequencer lamp_sequencer_chk #(.PRESET_EN(PRESET_EN)) i_chk (
   .clk        (clk),
   .rst        (rst),
   .cmd_i      (cmd_i),
   .preset_i   (preset_i),
   .lamp_red_o (lamp_red_o),
   .lamp_yel_o (lamp_yel_o),
   .lamp_grn_o (lamp_grn_o)
);

// File: tb/test_lamp_sequencer.sv
`timescale 1ns/1ps
module test_lamp_sequencer;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cmd = 1'b0;
   logic pre = 1'b0;
   logic red, yel, grn;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model code: 0 red, 1 green, 2 yellow, 3 trap
   int mstate = 0;

   always #5 clk = ~clk;

   lamp_sequencer #(.PRESET_EN(1'b1)) i_lamp_sequencer (
      .clk(clk), .rst(rst), .cmd_i(cmd), .preset_i(pre),
      .lamp_red_o(red), .lamp_yel_o(yel), .lamp_grn_o(grn)
   );

   // each entry {cmd, preset, red, yel, grn}; applied from red after reset
   localparam logic [4:0] VEC [0:15] = '{
      5'b10_001, 5'b00_010, 5'b00_100, 5'b00_100,
      5'b10_001, 5'b10_010, 5'b10_100, 5'b10_001,
      5'b01_010, 5'b10_100, 5'b11_010, 5'b00_100,
      5'b10_001, 5'b00_010, 5'b10_100, 5'b00_100
   };

   function automatic logic [2:0] lamps_of(int s);
      case (s)
         0: return 3'b100;
         1: return 3'b001;
         default: return 3'b010;
      endcase
   endfunction

   function automatic int next_of(int s, logic c, logic p);
      if (p) return 3;
      case (s)
         0: return c ? 1 : 0;
         1: return 2;
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(int s, logic p);
      if (p) return "R7";
      case (s)
         0: return "R3/R4";
         1: return "R5";
         2: return "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic check(string req, logic [2:0] got, logic [2:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: lamps rgy-order {r,y,g} got %b expected %b", req, got, exp);
      end
   endtask

   task automatic step(logic c, logic p, logic r);
      @(negedge clk);
      cmd = c; pre = p; rst = r;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      finish_run();
   end

   initial begin
      // R2: reset state
      step(1'b1, 1'b1, 1'b1);
      check("R2 reset with preset", {red, yel, grn}, 3'b100);
      step(1'b0, 1'b0, 1'b1);
      check("R2 reset", {red, yel, grn}, 3'b100);

      // vector table walk, also checks R1
      for (int i = 0; i < 16; i++) begin
         string t;
         t = tag_of(mstate, VEC[i][3]);
         step(VEC[i][4], VEC[i][3], 1'b0);
         mstate = next_of(mstate, VEC[i][4], VEC[i][3]);
         check(t, {red, yel, grn}, VEC[i][2:0]);
         checks++;
         if ($countones({red, yel, grn}) != 1) begin
            errors++;
            $display("FAIL R1: lamps got %b expected one-hot", {red, yel, grn});
         end
      end

      // R4: long park on red
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0);
      check("R4 park", {red, yel, grn}, 3'b100);

      // R2: reset while green is lit
      step(1'b1, 1'b0, 1'b0);
      check("R3 go", {red, yel, grn}, 3'b001);
      step(1'b1, 1'b0, 1'b1);
      check("R2 reset from green", {red, yel, grn}, 3'b100);

      // R7: preset overrides step from green; R8 exit with cmd low
      step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0);
      check("R7 preset from green", {red, yel, grn}, 3'b010);
      step(1'b0, 1'b0, 1'b0);
      check("R8 exit cmd low", {red, yel, grn}, 3'b100);
      // R7: repeated preset holds trap
      step(1'b1, 1'b1, 1'b0);
      step(1'b1, 1'b1, 1'b0);
      check("R7 preset held", {red, yel, grn}, 3'b010);
      step(1'b1, 1'b0, 1'b0);
      check("R8 exit cmd high", {red, yel, grn}, 3'b100);

      // random phase against model, R1 each cycle
      mstate = 0;
      for (int i = 0; i < 400; i++) begin
         logic c, p;
         string t;
         c = 1'($urandom_range(0, 1));
         p = ($urandom_range(0, 9) == 0);
         t = tag_of(mstate, p);
         step(c, p, 1'b0);
         mstate = next_of(mstate, c, p);
         check(t, {red, yel, grn}, lamps_of(mstate));
         checks++;
         if ($countones({red, yel, grn}) != 1) begin
            errors++;
            $display("FAIL R1: lamps got %b expected one-hot", {red, yel, grn});
         end
      end
      finish_run();
   end
endmodule